// File: doc/BRIEF.md
# Banked Internal Data Memory

This block is the on-chip scratch data store of an 8-bit microcontroller core. It holds up to 256 bytes of RAM and serves four kinds of byte access: direct, indirect, stack and register-bank relative. Whether an address in the top half of the space (80h–FFh) reaches RAM or the special function register (SFR) bus depends on the access mode. Direct accesses there go to the SFR bus. Indirect and stack accesses go to the upper RAM.

A separate bit port works on a 256-entry bit address space. The lower half maps onto the sixteen RAM bytes at 20h–2Fh, and the upper half maps onto single bits of SFRs whose byte address ends in 0h or 8h. Each bit operation finishes in one clock cycle as a read-modify-write of the containing byte, so the byte view and the bit view of the same storage always agree.

A build parameter selects a reduced 128-byte variant. In that variant, indirect and stack accesses to the top half read as zero and their writes are dropped.

Top module: `idata_store`

## Requirements
- R1: A direct access (byte_mode 0) to 00h–7Fh reads or writes RAM. A read returns its data on byte_rdata with byte_rvalid high in the cycle after the request. A write raises no byte_rvalid.
- R2: A direct access to 80h–FFh goes to the SFR bus in the request cycle. sfr_addr equals byte_addr, and sfr_re (read) or sfr_we with sfr_wdata (write) is raised. A read returns the sfr_rdata sampled in that cycle, one cycle later. RAM is left untouched.
- R3: Indirect (byte_mode 1) and stack (byte_mode 3) accesses reach RAM at every address 00h–FFh and never drive the SFR bus. Upper RAM and the SFR at the same address are separate storage.
- R4: A register access (byte_mode 2) uses RAM byte {3'b000, bank_sel, byte_addr[2:0]}. byte_addr[7:3] has no effect.
- R5: A bit address below 80h selects RAM byte 20h + bit_addr[6:3], at bit position bit_addr[2:0].
- R6: The bit_op codes are 1 set, 2 clear, 3 complement, 4 load bit_cin and 5 test. Codes 1–4 change only the selected bit of the byte. Code 5 changes nothing. Codes 0, 6 and 7 are ignored.
- R7: For a bit request with a valid op, bit_rvalid rises in the next cycle, and bit_rdata carries the selected bit's value from before the operation.
- R8: A bit address of 80h or above goes to the SFR byte {bit_addr[7:3], 3'b000} in the same cycle. sfr_re is raised, and for codes 1–4 sfr_we is raised too, with the modified byte.
- R9: When byte_en and bit_en are high in the same cycle, the byte request is served. The bit request is dropped: no state change and no bit_rvalid.
- R10: With UPPER_RAM = 0, indirect and stack reads of 80h–FFh return zero, and writes to that range have no effect.
- R11: After reset, byte_rvalid, bit_rvalid, byte_rdata and bit_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_en | input | 1 | Byte request |
| byte_we | input | 1 | Byte write (1) or read (0) |
| byte_mode | input | 2 | 0 direct, 1 indirect, 2 register, 3 stack |
| byte_addr | input | 8 | Byte address or register number |
| byte_wdata | input | 8 | Byte write data |
| bank_sel | input | 2 | Active register bank |
| byte_rdata | output | 8 | Byte read data |
| byte_rvalid | output | 1 | Byte read data valid |
| bit_en | input | 1 | Bit request |
| bit_op | input | 3 | Bit operation code |
| bit_addr | input | 8 | Bit address |
| bit_cin | input | 1 | Carry value for the load operation |
| bit_rdata | output | 1 | Bit value before the operation |
| bit_rvalid | output | 1 | Bit result valid |
| sfr_re | output | 1 | SFR read strobe |
| sfr_we | output | 1 | SFR write strobe |
| sfr_addr | output | 8 | SFR byte address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, valid in the same cycle |

## Verification
The assertions check the following on every cycle:
- Direct upper accesses drive the SFR bus with the request's own address and direction.
- Register, indirect and stack accesses never touch that bus.
- Bit requests below 80h never touch that bus.
- SFR bit writes differ from the byte read back in at most one bit, at the aligned address.
- Read and bit results arrive one cycle later, and a bit request that clashes with a byte request never yields a result.

The following can only be shown by the bench's scenarios, because each depends on a value stored earlier:
- The exact bit semantics.
- The mapping of bank registers.
- Coherence between the byte and bit views.
- The separation of upper RAM from the SFR at the same address.
- The zero reads of the reduced variant.

// File: rtl/idm_pkg.sv
package idm_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int BANK_W = 2;

    typedef enum logic [1:0] {
        AM_DIRECT   = 2'd0,
        AM_INDIRECT = 2'd1,
        AM_REGBANK  = 2'd2,
        AM_STACK    = 2'd3
    } acc_mode_e;

    typedef enum logic [2:0] {
        BOP_NOP  = 3'd0,
        BOP_SET  = 3'd1,
        BOP_CLR  = 3'd2,
        BOP_CPL  = 3'd3,
        BOP_LOAD = 3'd4,
        BOP_TEST = 3'd5,
        BOP_RSV6 = 3'd6,
        BOP_RSV7 = 3'd7
    } bit_op_e;

    localparam logic [ADDR_W-1:0] FLAG_BYTE_BASE = 8'h20;

    typedef struct packed {
        logic [DATA_W-1:0] byte_rdata;
        logic              byte_rvalid;
        logic              bit_rdata;
        logic              bit_rvalid;
    } rsp_t;
endpackage

// File: rtl/idm_byte_decode.sv
module idm_byte_decode
    import idm_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BANK_W    = 2,
    parameter int RN_W      = 3,
    parameter bit UPPER_RAM = 1'b1
) (
    input  logic              en,
    input  acc_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    output logic              ram_hit,
    output logic              sfr_hit,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int ZERO_W = ADDR_W - BANK_W - RN_W;

    logic upper;
    assign upper = addr[ADDR_W-1];

    always_comb begin
        ram_hit  = 1'b0;
        sfr_hit  = 1'b0;
        eff_addr = addr;
        if (en) begin
            unique case (mode)
                AM_DIRECT: begin
                    sfr_hit = upper;
                    ram_hit = !upper;
                end
                AM_REGBANK: begin
                    eff_addr = {{ZERO_W{1'b0}}, bank, addr[RN_W-1:0]};
                    ram_hit  = 1'b1;
                end
                default: begin
                    ram_hit = !upper || UPPER_RAM;
                end
            endcase
        end
    end
endmodule

// File: rtl/idm_bit_decode.sv
module idm_bit_decode
    import idm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] bit_addr,
    output logic              is_sfr,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int ROW_W = ADDR_W - 1 - IDX_W;

    always_comb begin
        is_sfr = bit_addr[ADDR_W-1];
        idx    = bit_addr[IDX_W-1:0];
        if (is_sfr) begin
            byte_addr = {bit_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
        end else begin
            byte_addr = FLAG_BYTE_BASE +
                        {{(ADDR_W-ROW_W){1'b0}}, bit_addr[ADDR_W-2:IDX_W]};
        end
    end
endmodule

// File: rtl/idm_bit_alu.sv
module idm_bit_alu
    import idm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] old_byte,
    input  logic [IDX_W-1:0]  idx,
    input  bit_op_e           op,
    input  logic              cin,
    output logic [DATA_W-1:0] new_byte,
    output logic              old_bit,
    output logic              modifies
);
    assign old_bit = old_byte[idx];

    always_comb begin
        unique case (op)
            BOP_SET, BOP_CLR, BOP_CPL, BOP_LOAD: modifies = 1'b1;
            default:                             modifies = 1'b0;
        endcase
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic hit;
        assign hit = (idx == IDX_W'(i));
        always_comb begin
            new_byte[i] = old_byte[i];
            if (hit) begin
                unique case (op)
                    BOP_SET:  new_byte[i] = 1'b1;
                    BOP_CLR:  new_byte[i] = 1'b0;
                    BOP_CPL:  new_byte[i] = !old_byte[i];
                    BOP_LOAD: new_byte[i] = cin;
                    default:  new_byte[i] = old_byte[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rdata = mem_q[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end
endmodule

// File: rtl/idata_store.sv
module idata_store
    import idm_pkg::*;
#(
    parameter bit UPPER_RAM    = 1'b1,
    parameter int REG_PER_BANK = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_en,
    input  logic              byte_we,
    input  logic [1:0]        byte_mode,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [DATA_W-1:0] byte_wdata,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [DATA_W-1:0] byte_rdata,
    output logic              byte_rvalid,
    input  logic              bit_en,
    input  logic [2:0]        bit_op,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic              bit_cin,
    output logic              bit_rdata,
    output logic              bit_rvalid,
    output logic              sfr_re,
    output logic              sfr_we,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata
);
    localparam int RAM_DEPTH = UPPER_RAM ? (1 << ADDR_W) : (1 << (ADDR_W - 1));
    localparam int RAM_AW    = $clog2(RAM_DEPTH);
    localparam int RN_W      = $clog2(REG_PER_BANK);
    localparam int IDX_W     = $clog2(DATA_W);

    acc_mode_e mode;
    bit_op_e   bop;
    assign mode = acc_mode_e'(byte_mode);
    assign bop  = bit_op_e'(bit_op);

    logic              dec_ram_hit, dec_sfr_hit;
    logic [ADDR_W-1:0] dec_addr;

    idm_byte_decode #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .RN_W(RN_W), .UPPER_RAM(UPPER_RAM)
    ) byte_dec_i (
        .en(byte_en), .mode(mode), .addr(byte_addr), .bank(bank_sel),
        .ram_hit(dec_ram_hit), .sfr_hit(dec_sfr_hit), .eff_addr(dec_addr)
    );

    logic              bdec_sfr;
    logic [ADDR_W-1:0] bdec_byte;
    logic [IDX_W-1:0]  bdec_idx;

    idm_bit_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) bit_dec_i (
        .bit_addr(bit_addr), .is_sfr(bdec_sfr), .byte_addr(bdec_byte), .idx(bdec_idx)
    );

    logic [DATA_W-1:0] ram_rdata, old_byte, new_byte;
    logic              old_bit, bit_modifies;

    idm_bit_alu #(.DATA_W(DATA_W), .IDX_W(IDX_W)) bit_alu_i (
        .old_byte(old_byte), .idx(bdec_idx), .op(bop), .cin(bit_cin),
        .new_byte(new_byte), .old_bit(old_bit), .modifies(bit_modifies)
    );

    logic              byte_go, bit_go, bop_valid;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    rsp_t              rsp_d, rsp_q;

    always_comb begin
        unique case (bop)
            BOP_SET, BOP_CLR, BOP_CPL, BOP_LOAD, BOP_TEST: bop_valid = 1'b1;
            default:                                       bop_valid = 1'b0;
        endcase
        byte_go  = byte_en;
        bit_go   = bit_en && !byte_en && bop_valid;
        ram_addr = byte_go ? dec_addr : bdec_byte;
        old_byte = bdec_sfr ? sfr_rdata : ram_rdata;
    end

    idm_ram #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W), .AW(RAM_AW)) ram_i (
        .clk(clk), .we(ram_we), .addr(ram_addr[RAM_AW-1:0]),
        .wdata(ram_wdata), .rdata(ram_rdata)
    );

    always_comb begin
        rsp_d     = rsp_q;
        ram_we    = 1'b0;
        ram_wdata = byte_wdata;
        sfr_re    = 1'b0;
        sfr_we    = 1'b0;
        sfr_addr  = byte_addr;
        sfr_wdata = byte_wdata;

        rsp_d.byte_rvalid = byte_go && !byte_we;
        rsp_d.bit_rvalid  = bit_go;

        if (byte_go) begin
            if (dec_sfr_hit) begin
                sfr_re = !byte_we;
                sfr_we = byte_we;
            end
            ram_we = dec_ram_hit && byte_we;
            if (!byte_we) begin
                if (dec_ram_hit)      rsp_d.byte_rdata = ram_rdata;
                else if (dec_sfr_hit) rsp_d.byte_rdata = sfr_rdata;
                else                  rsp_d.byte_rdata = '0;
            end
        end else if (bit_go) begin
            rsp_d.bit_rdata = old_bit;
            if (bdec_sfr) begin
                sfr_addr  = bdec_byte;
                sfr_re    = 1'b1;
                sfr_we    = bit_modifies;
                sfr_wdata = new_byte;
            end else begin
                ram_we    = bit_modifies;
                ram_wdata = new_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign byte_rdata  = rsp_q.byte_rdata;
    assign byte_rvalid = rsp_q.byte_rvalid;
    assign bit_rdata   = rsp_q.bit_rdata;
    assign bit_rvalid  = rsp_q.bit_rvalid;

    // R2
    direct_upper_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && byte_mode == 2'd0 && byte_addr[ADDR_W-1]) |->
        (sfr_addr == byte_addr && sfr_we == byte_we && sfr_re == !byte_we));

    // R3 R4
    ram_mode_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && byte_mode != 2'd0) |-> (!sfr_re && !sfr_we));

    // R1
    read_resp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && !byte_we) |=> byte_rvalid);

    // R9
    byte_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en |=> !bit_rvalid);

    // R5
    ram_bit_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !byte_en && !bit_addr[ADDR_W-1]) |-> (!sfr_re && !sfr_we));

    // R8
    sfr_bit_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !byte_en && bit_addr[ADDR_W-1] && bit_op >= 3'd1 && bit_op <= 3'd5) |->
        (sfr_re && sfr_addr[IDX_W-1:0] == '0 && sfr_addr[ADDR_W-1:IDX_W] == bit_addr[ADDR_W-1:IDX_W]));

    // R6
    sfr_bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !byte_en && bit_addr[ADDR_W-1] && bit_op >= 3'd1 && bit_op <= 3'd4) |->
        (sfr_we && $countones(sfr_wdata ^ sfr_rdata) <= 1));

    // R7
    bit_resp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !byte_en && bit_op >= 3'd1 && bit_op <= 3'd5) |=> bit_rvalid);
endmodule

// File: tb/idata_store_tb.sv
`timescale 1ns/1ps
module idata_store_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_en = 1'b0, byte_we = 1'b0;
    logic [1:0] byte_mode = 2'd0;
    logic [7:0] byte_addr = 8'h00, byte_wdata = 8'h00;
    logic [1:0] bank_sel = 2'd0;
    logic       bit_en = 1'b0;
    logic [2:0] bit_op = 3'd0;
    logic [7:0] bit_addr = 8'h00;
    logic       bit_cin = 1'b0;

    logic [7:0] byte_rdata, sm_byte_rdata;
    logic       byte_rvalid, sm_byte_rvalid;
    logic       bit_rdata, bit_rvalid, sm_bit_rdata, sm_bit_rvalid;
    logic       sfr_re, sfr_we, sm_sfr_re, sm_sfr_we;
    logic [7:0] sfr_addr, sfr_wdata, sfr_rdata, sm_sfr_addr, sm_sfr_wdata, sm_sfr_rdata;

    logic [7:0] sfr_model [256];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic       s_sfr_re, s_sfr_we;
    logic [7:0] s_sfr_addr, s_sfr_wdata;
    logic [7:0] r_data, r_small;
    logic       r_valid, r_small_valid, r_bit, r_bitv;

    always #2.5 clk = ~clk;

    assign sfr_rdata    = sfr_model[sfr_addr];
    assign sm_sfr_rdata = sfr_model[sm_sfr_addr];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) sfr_model[i] <= 8'h00;
        end else if (sfr_we) begin
            sfr_model[sfr_addr] <= sfr_wdata;
        end
    end

    idata_store dut_i (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .byte_we(byte_we),
        .byte_mode(byte_mode), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
        .bank_sel(bank_sel), .byte_rdata(byte_rdata), .byte_rvalid(byte_rvalid),
        .bit_en(bit_en), .bit_op(bit_op), .bit_addr(bit_addr), .bit_cin(bit_cin),
        .bit_rdata(bit_rdata), .bit_rvalid(bit_rvalid), .sfr_re(sfr_re), .sfr_we(sfr_we),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    idata_store #(.UPPER_RAM(1'b0)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .byte_we(byte_we),
        .byte_mode(byte_mode), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
        .bank_sel(bank_sel), .byte_rdata(sm_byte_rdata), .byte_rvalid(sm_byte_rvalid),
        .bit_en(bit_en), .bit_op(bit_op), .bit_addr(bit_addr), .bit_cin(bit_cin),
        .bit_rdata(sm_bit_rdata), .bit_rvalid(sm_bit_rvalid), .sfr_re(sm_sfr_re),
        .sfr_we(sm_sfr_we), .sfr_addr(sm_sfr_addr), .sfr_wdata(sm_sfr_wdata),
        .sfr_rdata(sm_sfr_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // starts and ends at a falling edge
    task automatic byte_req(input logic we, input logic [1:0] mode, input logic [7:0] addr,
                            input logic [7:0] wd, input logic [1:0] bank);
        byte_en = 1'b1; byte_we = we; byte_mode = mode; byte_addr = addr;
        byte_wdata = wd; bank_sel = bank;
        #1;
        s_sfr_re = sfr_re; s_sfr_we = sfr_we; s_sfr_addr = sfr_addr; s_sfr_wdata = sfr_wdata;
        @(negedge clk);
        r_data = byte_rdata; r_valid = byte_rvalid;
        r_small = sm_byte_rdata; r_small_valid = sm_byte_rvalid;
        byte_en = 1'b0; byte_we = 1'b0;
    endtask

    task automatic bit_req(input logic [2:0] op, input logic [7:0] addr, input logic cin);
        bit_en = 1'b1; bit_op = op; bit_addr = addr; bit_cin = cin;
        #1;
        s_sfr_re = sfr_re; s_sfr_we = sfr_we; s_sfr_addr = sfr_addr; s_sfr_wdata = sfr_wdata;
        @(negedge clk);
        r_bit = bit_rdata; r_bitv = bit_rvalid;
        bit_en = 1'b0; bit_op = 3'd0;
    endtask

    task automatic t_reset();
        check("R11 byte_rvalid", {7'd0, byte_rvalid}, 8'h00);
        check("R11 bit_rvalid", {7'd0, bit_rvalid}, 8'h00);
        check("R11 byte_rdata", byte_rdata, 8'h00);
        check("R11 bit_rdata", {7'd0, bit_rdata}, 8'h00);
    endtask

    task automatic t_direct_low();
        byte_req(1'b1, 2'd0, 8'h30, 8'h45, 2'd0);
        check("R1 write no rvalid", {7'd0, r_valid}, 8'h00);
        check("R1 low write no sfr", {6'd0, s_sfr_re, s_sfr_we}, 8'h00);
        byte_req(1'b0, 2'd0, 8'h30, 8'h00, 2'd0);
        check("R1 read rvalid", {7'd0, r_valid}, 8'h01);
        check("R1 read data", r_data, 8'h45);
        byte_req(1'b1, 2'd0, 8'h7F, 8'hC3, 2'd0);
        byte_req(1'b0, 2'd0, 8'h7F, 8'h00, 2'd0);
        check("R1 boundary 7F", r_data, 8'hC3);
    endtask

    task automatic t_upper_split();
        byte_req(1'b1, 2'd1, 8'h90, 8'hA5, 2'd0);
        check("R3 indirect write no sfr", {6'd0, s_sfr_re, s_sfr_we}, 8'h00);
        byte_req(1'b1, 2'd0, 8'h90, 8'h3C, 2'd0);
        check("R2 direct write strobe", {6'd0, s_sfr_re, s_sfr_we}, 8'h01);
        check("R2 direct write addr", s_sfr_addr, 8'h90);
        check("R2 direct write data", s_sfr_wdata, 8'h3C);
        byte_req(1'b0, 2'd1, 8'h90, 8'h00, 2'd0);
        check("R3 indirect reads RAM not SFR", r_data, 8'hA5);
        check("R10 small indirect upper reads zero", r_small, 8'h00);
        check("R10 small read still valid", {7'd0, r_small_valid}, 8'h01);
        byte_req(1'b0, 2'd3, 8'h90, 8'h00, 2'd0);
        check("R3 stack reads RAM", r_data, 8'hA5);
        byte_req(1'b0, 2'd0, 8'h90, 8'h00, 2'd0);
        check("R2 direct read strobe", {6'd0, s_sfr_re, s_sfr_we}, 8'h02);
        check("R2 direct reads SFR", r_data, 8'h3C);
        byte_req(1'b1, 2'd3, 8'hFF, 8'h5A, 2'd0);
        byte_req(1'b0, 2'd1, 8'hFF, 8'h00, 2'd0);
        check("R3 stack write at FF", r_data, 8'h5A);
        check("R10 small ignores upper write", r_small, 8'h00);
        byte_req(1'b0, 2'd0, 8'h30, 8'h00, 2'd0);
        check("R10 small lower RAM works", r_small, 8'h45);
    endtask

    task automatic t_regbank();
        for (int b = 0; b < 4; b++) begin
            byte_req(1'b1, 2'd2, 8'hAD, 8'h50 + 8'(b), 2'(b));
            check("R4 reg write no sfr", {6'd0, s_sfr_re, s_sfr_we}, 8'h00);
        end
        for (int b = 0; b < 4; b++) begin
            byte_req(1'b0, 2'd0, 8'(b * 8 + 5), 8'h00, 2'd0);
            check("R4 bank register at direct address", r_data, 8'h50 + 8'(b));
        end
        byte_req(1'b0, 2'd2, 8'hF5, 8'h00, 2'd2);
        check("R4 upper address bits ignored", r_data, 8'h52);
    endtask

    task automatic t_bit_ram();
        byte_req(1'b1, 2'd0, 8'h22, 8'h00, 2'd0);
        bit_req(3'd1, 8'h13, 1'b0);
        check("R7 set old bit", {7'd0, r_bit}, 8'h00);
        check("R7 set rvalid", {7'd0, r_bitv}, 8'h01);
        check("R5 bit ops no sfr", {6'd0, s_sfr_re, s_sfr_we}, 8'h00);
        byte_req(1'b0, 2'd0, 8'h22, 8'h00, 2'd0);
        check("R6 set bit 3 of 22h", r_data, 8'h08);
        bit_req(3'd3, 8'h10, 1'b0);
        byte_req(1'b0, 2'd0, 8'h22, 8'h00, 2'd0);
        check("R6 complement bit 0", r_data, 8'h09);
        bit_req(3'd2, 8'h13, 1'b0);
        check("R7 clear old bit", {7'd0, r_bit}, 8'h01);
        byte_req(1'b0, 2'd0, 8'h22, 8'h00, 2'd0);
        check("R6 clear bit 3", r_data, 8'h01);
        bit_req(3'd4, 8'h17, 1'b1);
        byte_req(1'b0, 2'd0, 8'h22, 8'h00, 2'd0);
        check("R6 load carry into bit 7", r_data, 8'h81);
        bit_req(3'd5, 8'h17, 1'b0);
        check("R7 test returns bit", {7'd0, r_bit}, 8'h01);
        byte_req(1'b0, 2'd0, 8'h22, 8'h00, 2'd0);
        check("R6 test leaves byte", r_data, 8'h81);
        bit_req(3'd6, 8'h10, 1'b0);
        check("R6 reserved op no rvalid", {7'd0, r_bitv}, 8'h00);
        byte_req(1'b0, 2'd0, 8'h22, 8'h00, 2'd0);
        check("R6 reserved op no change", r_data, 8'h81);
        byte_req(1'b1, 2'd0, 8'h2F, 8'h00, 2'd0);
        bit_req(3'd1, 8'h7F, 1'b0);
        byte_req(1'b0, 2'd0, 8'h2F, 8'h00, 2'd0);
        check("R5 bit 7Fh is 2Fh bit 7", r_data, 8'h80);
        byte_req(1'b1, 2'd0, 8'h20, 8'h01, 2'd0);
        bit_req(3'd5, 8'h00, 1'b0);
        check("R5 bit 00h is 20h bit 0 (byte to bit view)", {7'd0, r_bit}, 8'h01);
    endtask

    task automatic t_bit_sfr();
        byte_req(1'b1, 2'd1, 8'hA8, 8'h77, 2'd0);
        byte_req(1'b1, 2'd0, 8'hA8, 8'h00, 2'd0);
        bit_req(3'd1, 8'hAD, 1'b0);
        check("R8 sfr bit byte address", s_sfr_addr, 8'hA8);
        check("R8 sfr bit strobes", {6'd0, s_sfr_re, s_sfr_we}, 8'h03);
        check("R8 sfr bit write data", s_sfr_wdata, 8'h20);
        bit_req(3'd3, 8'hA8, 1'b0);
        byte_req(1'b0, 2'd0, 8'hA8, 8'h00, 2'd0);
        check("R8 sfr byte after two bit ops", r_data, 8'h21);
        bit_req(3'd5, 8'hAD, 1'b0);
        check("R8 sfr test strobes", {6'd0, s_sfr_re, s_sfr_we}, 8'h02);
        check("R7 sfr test returns bit", {7'd0, r_bit}, 8'h01);
        byte_req(1'b0, 2'd1, 8'hA8, 8'h00, 2'd0);
        check("R8 upper RAM untouched by sfr bits", r_data, 8'h77);
    endtask

    task automatic t_priority();
        byte_en = 1'b1; byte_we = 1'b0; byte_mode = 2'd0; byte_addr = 8'h22;
        bit_en = 1'b1; bit_op = 3'd2; bit_addr = 8'h10; bit_cin = 1'b0;
        @(negedge clk);
        r_data = byte_rdata; r_valid = byte_rvalid; r_bitv = bit_rvalid;
        byte_en = 1'b0; bit_en = 1'b0; bit_op = 3'd0;
        check("R9 byte served", r_data, 8'h81);
        check("R9 bit dropped no rvalid", {7'd0, r_bitv}, 8'h00);
        byte_req(1'b0, 2'd0, 8'h22, 8'h00, 2'd0);
        check("R9 bit dropped no change", r_data, 8'h81);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct_low();
        t_upper_split();
        t_regbank();
        t_bit_ram();
        t_bit_sfr();
        t_priority();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule